// File: doc/BRIEF.md
# Monochrome Framebuffer VGA Scan-Out

This block produces 640x400, 70 Hz monochrome VGA timing from one pixel clock. It reads a linear one-bit-per-pixel framebuffer through a synchronous word read port and shifts the pixels out serially on a single video line. Alongside the video it drives horizontal and vertical sync and two timing strobes: one for each line and one for each frame.

A horizontal counter spans 800 pixel clocks per line. A vertical state machine advances on line boundaries through five named phases: PH_PRE (lines before the vertical pulse), PH_SYNC (pulse), PH_BACK (back porch), PH_SHOW (displayed lines) and PH_TAIL (blank lines up to the frame end). The transitions are:
- PRE to SYNC on entering line VS_ON.
- SYNC to BACK on entering line VS_OFF.
- BACK to SHOW on entering line SHOW_FIRST.
- SHOW to TAIL on entering line SHOW_FIRST+SHOW_LINES.
- TAIL to PRE when the line counter wraps to 0.

On each PH_SHOW line, a fetch unit reads the row's words into a two-entry prefetch queue at the start of the line. A serializer then plays the pixels out inside a fixed window that lies clear of the horizontal sync pulse.

The framebuffer memory is read-only from this block's side. The memory returns the data one clock after a read request. All video-side outputs are registered, so they share one clock of latency relative to the internal counters.

Top module: `mono_vga_scan`

## Requirements
- R1: A line lasts H_TOTAL (800) clocks. `line_stb` is high for exactly one clock per line, and the line's column 0 is that clock.
- R2: `hsync_n` is low at columns HS_ON through HS_OFF-1 of every line (16 to 47, 32 clocks) and high elsewhere.
- R3: A frame lasts V_TOTAL (449) lines. `frame_stb` is high only together with `line_stb` on line 0, so consecutive frame strobes are V_TOTAL*H_TOTAL clocks apart.
- R4: The vertical phase follows the order PH_PRE, PH_SYNC, PH_BACK, PH_SHOW, PH_TAIL and then back to PH_PRE, changing only at line boundaries.
- R5: `vsync` is high for all of lines VS_ON to VS_OFF-1 (lines 2 and 3) and low on every other line.
- R6: Lines SHOW_FIRST to SHOW_FIRST+SHOW_LINES-1 (39 to 438, 400 lines) are displayed. On every other line, `video` stays 0 and no framebuffer read is issued.
- R7: Each displayed row r issues exactly ACT_PIX/WORD_W (20) reads of WORD_W-bit words. The byte addresses are FB_BASE + r*ACT_PIX/8 + 4k for k = 0, 1, ... in ascending order, so the row stride is 80 bytes with no padding. The row pointer returns to FB_BASE at each frame wrap.
- R8: `fb_rd_data` is taken one clock after the matching `fb_rd_en`. The prefetch queue holds a word before each word boundary of the pixel stream, so the serializer never waits on the memory.
- R9: Pixel p of a row comes from byte p/8 of the row, bit 7-(p mod 8), so the most significant bit goes first. Byte k of a fetched word occupies bits [8k+7:8k], so lower addresses play first.
- R10: On a displayed line, pixel p appears on `video` at column ACT_START+p (default 64, giving columns 64 to 703). `video` is 0 at all other columns.
- R11: While `rst` is high, `hsync_n` is 1 and `vsync`, `video`, `line_stb`, `frame_stb` and `fb_rd_en` are 0. After release, the first clock brings `line_stb` and `frame_stb` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_rd_en | output | 1 | Framebuffer read request |
| fb_rd_addr | output | ADDR_W | Byte address of the requested word (word aligned) |
| fb_rd_data | input | WORD_W | Read data, valid one clock after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| video | output | 1 | Serial monochrome pixel, 1 = lit |
| line_stb | output | 1 | One-clock pulse at column 0 of each line |
| frame_stb | output | 1 | One-clock pulse at column 0 of line 0 |

## Verification
A slipped horizontal count shows up within one line: it moves the sync pulse, the line strobe and the pixel window all by the same amount. A vertical phase machine out of step with its line counter moves the vertical pulse or the displayed band within one frame, and a wrong pointer reset shows as the wrong image in the first displayed row of the second frame. A byte-order or bit-order error in the serializer changes the video pattern within the first 32 pixels of the first displayed line. A queue that is starved or overfilled drops or repeats whole 32-pixel groups.

// File: rtl/mvga_pkg.sv
package mvga_pkg;

    // Vertical phases of a frame, visited in declaration order.
    typedef enum logic [2:0] {
        PH_PRE  = 3'd0,
        PH_SYNC = 3'd1,
        PH_BACK = 3'd2,
        PH_SHOW = 3'd3,
        PH_TAIL = 3'd4
    } vphase_e;

endpackage

// File: rtl/mvga_hcount.sv
module mvga_hcount #(
    parameter int H_TOTAL = 800
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(H_TOTAL)-1:0] hcnt,
    output logic                       line_last
);
    localparam int HW = $clog2(H_TOTAL);

    assign line_last = (hcnt == HW'(H_TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst)            hcnt <= '0;
        else if (line_last) hcnt <= '0;
        else                hcnt <= hcnt + 1'b1;
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        line_last |=> (hcnt == '0)); // R1
    AST_H_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(hcnt) < H_TOTAL); // R1

endmodule

// File: rtl/mvga_vseq.sv
module mvga_vseq
    import mvga_pkg::*;
#(
    parameter int V_TOTAL    = 449,
    parameter int VS_ON      = 2,
    parameter int VS_OFF     = 4,
    parameter int SHOW_FIRST = 39,
    parameter int SHOW_LINES = 400
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_last,
    output logic [$clog2(V_TOTAL)-1:0] vcnt,
    output vphase_e                    phase,
    output logic                       frame_last
);
    localparam int VW       = $clog2(V_TOTAL);
    localparam int SHOW_END = SHOW_FIRST + SHOW_LINES;

    logic [VW-1:0] vnext;
    vphase_e       phase_n;

    assign frame_last = line_last && (vcnt == VW'(V_TOTAL - 1));
    assign vnext      = frame_last ? '0 : vcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)            vcnt <= '0;
        else if (line_last) vcnt <= vnext;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) phase <= PH_PRE;
        else     phase <= phase_n;
    end

    // Next-state logic: moves only on a line boundary
    always_comb begin
        phase_n = phase;
        if (line_last) begin
            unique case (phase)
                PH_PRE:  if (vnext == VW'(VS_ON))      phase_n = PH_SYNC;
                PH_SYNC: if (vnext == VW'(VS_OFF))     phase_n = PH_BACK;
                PH_BACK: if (vnext == VW'(SHOW_FIRST)) phase_n = PH_SHOW;
                PH_SHOW: if (vnext == VW'(SHOW_END))   phase_n = PH_TAIL;
                PH_TAIL: if (vnext == '0)              phase_n = PH_PRE;
                default:                               phase_n = PH_PRE;
            endcase
        end
    end

    AST_V_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(vcnt) < V_TOTAL); // R3
    AST_SYNC_BAND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SYNC) == (int'(vcnt) >= VS_ON && int'(vcnt) < VS_OFF)); // R5
    AST_SHOW_BAND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHOW) == (int'(vcnt) >= SHOW_FIRST && int'(vcnt) < SHOW_END)); // R6
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !line_last |=> $stable(phase)); // R4

endmodule

// File: rtl/mvga_fetch.sv
module mvga_fetch #(
    parameter int ADDR_W     = 15,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 20,
    parameter int FB_BASE    = 0,
    parameter int DEPTH      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              show_line,
    input  logic              frame_last,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              head_vld,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data
);
    localparam int BYTES_W = WORD_W / 8;
    localparam int WCW     = $clog2(LINE_WORDS + 1);
    localparam int PW      = $clog2(DEPTH);
    localparam int CW      = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] ptr;
    logic [WCW-1:0]    left;
    logic              rd_q;
    logic [WORD_W-1:0] slot [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     count;

    // Credit check: queued words plus the one in flight must fit.
    assign rd_en    = (left != '0) && ((int'(count) + int'(rd_q)) < DEPTH);
    assign rd_addr  = ptr;
    assign head     = slot[rp];
    assign head_vld = (count != '0);

    always_ff @(posedge clk) begin
        if (rst)             ptr <= ADDR_W'(FB_BASE);
        else if (frame_last) ptr <= ADDR_W'(FB_BASE);
        else if (rd_en)      ptr <= ptr + ADDR_W'(BYTES_W);
    end

    always_ff @(posedge clk) begin
        if (rst)                          left <= '0;
        else if (line_start && show_line) left <= WCW'(LINE_WORDS);
        else if (rd_en)                   left <= left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_en;
    end

    always_ff @(posedge clk) begin
        if (rd_q) slot[wp] <= rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (rd_q) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
            if (pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
            count <= count + CW'(rd_q) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH); // R8
    AST_READ_ON_SHOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> show_line); // R6
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr) % BYTES_W == 0)); // R7

endmodule

// File: rtl/mvga_shift.sv
module mvga_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_on,
    input  logic [WORD_W-1:0] head,
    input  logic              head_vld,
    output logic              pop,
    output logic              pix_bit
);
    localparam int NB = WORD_W / 8;
    localparam int BW = $clog2(WORD_W);

    logic [WORD_W-1:0] ord;
    logic [WORD_W-1:0] sh;
    logic [BW-1:0]     bidx;

    // Lowest-address byte moves to the top so it plays first.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign ord[WORD_W-1-8*g -: 8] = head[8*g +: 8];
    end

    assign pop     = pix_on && (bidx == '0);
    assign pix_bit = (bidx == '0) ? ord[WORD_W-1] : sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bidx <= '0;
            sh   <= '0;
        end else if (pix_on) begin
            bidx <= bidx + 1'b1;
            sh   <= (bidx == '0) ? (ord << 1) : (sh << 1);
        end
    end

    AST_PREFETCH_READY: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_vld); // R8

endmodule

// File: rtl/mono_vga_scan.sv
module mono_vga_scan
    import mvga_pkg::*;
#(
    parameter int H_TOTAL    = 800,
    parameter int HS_ON      = 16,
    parameter int HS_OFF     = 48,
    parameter int ACT_START  = 64,
    parameter int ACT_PIX    = 640,
    parameter int V_TOTAL    = 449,
    parameter int VS_ON      = 2,
    parameter int VS_OFF     = 4,
    parameter int SHOW_FIRST = 39,
    parameter int SHOW_LINES = 400,
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 15,
    parameter int FB_BASE    = 0,
    parameter int PF_DEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fb_rd_en,
    output logic [ADDR_W-1:0] fb_rd_addr,
    input  logic [WORD_W-1:0] fb_rd_data,
    output logic              hsync_n,
    output logic              vsync,
    output logic              video,
    output logic              line_stb,
    output logic              frame_stb
);
    localparam int HW         = $clog2(H_TOTAL);
    localparam int VW         = $clog2(V_TOTAL);
    localparam int LINE_WORDS = ACT_PIX / WORD_W;
    localparam int ACT_END    = ACT_START + ACT_PIX;

    logic [HW-1:0]  hcnt;
    logic [VW-1:0]  vcnt;
    logic           line_last, frame_last;
    vphase_e        phase;
    logic           pix_on, pix_bit, pop;
    logic [WORD_W-1:0] head;
    logic           head_vld;

    mvga_hcount #(.H_TOTAL(H_TOTAL)) u_h (
        .clk(clk), .rst(rst), .hcnt(hcnt), .line_last(line_last)
    );

    mvga_vseq #(
        .V_TOTAL(V_TOTAL), .VS_ON(VS_ON), .VS_OFF(VS_OFF),
        .SHOW_FIRST(SHOW_FIRST), .SHOW_LINES(SHOW_LINES)
    ) u_v (
        .clk(clk), .rst(rst), .line_last(line_last),
        .vcnt(vcnt), .phase(phase), .frame_last(frame_last)
    );

    assign pix_on = (phase == PH_SHOW) &&
                    (int'(hcnt) >= ACT_START) && (int'(hcnt) < ACT_END);

    mvga_fetch #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
        .FB_BASE(FB_BASE), .DEPTH(PF_DEPTH)
    ) u_f (
        .clk(clk), .rst(rst),
        .line_start(hcnt == '0), .show_line(phase == PH_SHOW),
        .frame_last(frame_last), .pop(pop),
        .head(head), .head_vld(head_vld),
        .rd_en(fb_rd_en), .rd_addr(fb_rd_addr), .rd_data(fb_rd_data)
    );

    mvga_shift #(.WORD_W(WORD_W)) u_s (
        .clk(clk), .rst(rst), .pix_on(pix_on),
        .head(head), .head_vld(head_vld),
        .pop(pop), .pix_bit(pix_bit)
    );

    // Output process: every port one clock behind the counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n   <= 1'b1;
            vsync     <= 1'b0;
            video     <= 1'b0;
            line_stb  <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            hsync_n   <= !((int'(hcnt) >= HS_ON) && (int'(hcnt) < HS_OFF));
            vsync     <= (phase == PH_SYNC);
            video     <= pix_on && pix_bit;
            line_stb  <= (hcnt == '0);
            frame_stb <= (hcnt == '0) && (vcnt == '0);
        end
    end

    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> line_stb); // R3
    AST_HS_FALL_COL: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (int'(hcnt) == HS_ON + 1)); // R2
    AST_VIDEO_DARK: assert property (@(posedge clk) disable iff (rst)
        video |-> ($past(phase) == PH_SHOW)); // R6
    AST_VIDEO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        video |-> ($past(int'(hcnt)) >= ACT_START && $past(int'(hcnt)) < ACT_END)); // R10

endmodule

// File: tb/tb_mono_vga_scan.sv
`timescale 1ns/1ps
module tb_mono_vga_scan;
    localparam int T_H      = 120;
    localparam int T_HS_ON  = 4;
    localparam int T_HS_OFF = 12;
    localparam int T_ACT    = 16;
    localparam int T_PIX    = 64;
    localparam int T_V      = 30;
    localparam int T_VS_ON  = 2;
    localparam int T_VS_OFF = 4;
    localparam int T_SHOW0  = 8;
    localparam int T_SHOWN  = 16;
    localparam int ADDR_W   = 16;
    localparam int BASE     = 256;
    localparam int ROW_B    = T_PIX / 8;
    localparam int WORDS    = T_PIX / 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fb_rd_en, hsync_n, vsync, video, line_stb, frame_stb;
    logic [ADDR_W-1:0] fb_rd_addr;
    logic [31:0] fb_rd_data;

    int total = 0;
    int bad   = 0;
    int pos   = 0;

    always #4 clk = ~clk;

    mono_vga_scan #(
        .H_TOTAL(T_H), .HS_ON(T_HS_ON), .HS_OFF(T_HS_OFF),
        .ACT_START(T_ACT), .ACT_PIX(T_PIX),
        .V_TOTAL(T_V), .VS_ON(T_VS_ON), .VS_OFF(T_VS_OFF),
        .SHOW_FIRST(T_SHOW0), .SHOW_LINES(T_SHOWN),
        .WORD_W(32), .ADDR_W(ADDR_W), .FB_BASE(BASE), .PF_DEPTH(2)
    ) dut (
        .clk(clk), .rst(rst),
        .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .hsync_n(hsync_n), .vsync(vsync), .video(video),
        .line_stb(line_stb), .frame_stb(frame_stb)
    );

    function automatic logic [31:0] memf(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    // Memory with one clock of read latency
    always @(posedge clk) fb_rd_data <= memf(fb_rd_addr);

    function automatic logic pixbit(input int row, input int p);
        int ba;
        logic [31:0] w;
        ba = BASE + row * ROW_B + p / 8;
        w  = memf(ADDR_W'(ba - ba % 4));
        return w[8 * (ba % 4) + 7 - (p % 8)];
    endfunction

    // Probe table: absolute line, expected vsync, expected displayed
    localparam int NP = 12;
    localparam int PL  [NP] = '{0, 1, 2, 3, 4, 7, 8, 9, 15, 23, 24, 29};
    localparam bit PVS [NP] = '{0, 0, 1, 1, 0, 0, 0, 0, 0,  0,  0,  0};
    localparam bit PSH [NP] = '{0, 0, 0, 0, 0, 0, 1, 1, 1,  1,  0,  0};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        pos++;
    endtask

    task automatic check_line(input int labs, input bit evs, input bit esh);
        int ln, row, mhs, mvs, mst, mvid, nrd, maddr;
        bit ehs, est, efs, evid;
        ln = labs % T_V; row = ln - T_SHOW0;
        mhs = 0; mvs = 0; mst = 0; mvid = 0; nrd = 0; maddr = 0;
        while (pos < labs * T_H) step();
        for (int c = 0; c < T_H; c++) begin
            ehs  = !(c >= T_HS_ON && c < T_HS_OFF);
            est  = (c == 0);
            efs  = (c == 0) && (ln == 0);
            evid = esh && c >= T_ACT && c < T_ACT + T_PIX && pixbit(row, c - T_ACT);
            if (hsync_n !== ehs) mhs++;
            if (vsync !== evs) mvs++;
            if (line_stb !== est || frame_stb !== efs) mst++;
            if (video !== evid) mvid++;
            if (fb_rd_en === 1'b1) begin
                if (int'(fb_rd_addr) != BASE + row * ROW_B + 4 * nrd) maddr++;
                nrd++;
            end
            step();
        end
        chk(mhs == 0, "R2", $sformatf("hsync line %0d bad cycles", labs), mhs, 0);
        chk(mvs == 0, "R4/R5", $sformatf("vsync line %0d bad cycles", labs), mvs, 0);
        chk(mst == 0, "R1/R3", $sformatf("strobes line %0d bad cycles", labs), mst, 0);
        chk(mvid == 0, "R6/R9/R10", $sformatf("video line %0d bad pixels", labs), mvid, 0);
        chk(nrd == (esh ? WORDS : 0), "R6/R7", $sformatf("reads line %0d", labs),
            nrd, esh ? WORDS : 0);
        chk(maddr == 0, "R7/R8", $sformatf("read addresses line %0d", labs), maddr, 0);
    endtask

    task automatic check_reset_state();
        chk(hsync_n === 1'b1 && vsync === 1'b0 && video === 1'b0 &&
            line_stb === 1'b0 && frame_stb === 1'b0 && fb_rd_en === 1'b0,
            "R11", "outputs held in reset",
            {hsync_n, vsync, video, line_stb, frame_stb, fb_rd_en}, 6'b100000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        @(negedge clk);
        chk(frame_stb === 1'b1 && line_stb === 1'b1, "R11", "first clock after reset strobes",
            {line_stb, frame_stb}, 2'b11);
        pos = 0;

        // Table walk over the first frame
        for (int i = 0; i < NP; i++) check_line(PL[i], PVS[i], PSH[i]);

        // Frame period: next frame strobe exactly V*H clocks later
        while (pos < T_V * T_H) step();
        chk(frame_stb === 1'b1 && line_stb === 1'b1, "R3", "frame period",
            {line_stb, frame_stb}, 2'b11);

        // Second frame: pointer back to base, first and last displayed rows
        check_line(T_V + T_SHOW0, 1'b0, 1'b1);
        check_line(T_V + T_SHOW0 + T_SHOWN - 1, 1'b0, 1'b1);
        check_line(T_V + T_SHOW0 + T_SHOWN, 1'b0, 1'b0);

        // Reset in the middle of a displayed line
        while (pos < (T_V + T_SHOW0 + 3) * T_H + T_ACT + 5) step();
        rst = 1'b1;
        step(); step();
        check_reset_state();
        rst = 1'b0;
        @(negedge clk);
        chk(frame_stb === 1'b1, "R11", "restart after mid-line reset", frame_stb, 1);
        pos = 0;
        check_line(T_VS_ON, 1'b1, 1'b0);
        check_line(T_SHOW0, 1'b0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule